// File: doc/BRIEF.md
# Demand-Mode Byte DMA Channel

This block is one channel of a byte-wide DMA controller on a 20-bit physical address. A processor sets it up through an 8-bit register port. The registers are a mask command, a mode byte, a page value, the current address, the current count, a command that resets the byte pointer, and a status byte. The address and count are each 16 bits wide. They are written as two byte writes to the same select. A single pointer bit, shared by both registers, decides whether the next byte goes to the low half or the high half.

Once the channel is unmasked it serves the peripheral's request line in demand mode. It runs one transfer per clock while the request is held and stops when the request drops. Each transfer raises the acknowledge strobe together with either the memory-write strobe or the memory-read strobe, and drives the physical address. After each transfer the 16-bit offset steps up by one and the count steps down by one. The page never changes, so a transfer wraps inside its 64 KB window. The count is programmed as the length minus one. The transfer that starts with a count of zero is the last one. It pulses the terminal-count output, sets the terminal-count flag in status and masks the channel again.

Top module: `dma_demand_chan`

## Requirements
- R1: After reset the channel is masked, all transfer strobes are low, the pointer selects the low byte, and a status read returns 0x02 (bit 1 = masked, bit 0 = terminal-count flag).
- R2: While masked, the channel makes no transfer whatever the request input does. A write to select 4 with data bit 0 = 1 masks the channel, and with bit 0 = 0 unmasks it.
- R3: Select 0 (offset) and select 1 (count) take bytes low first, then high. Each write to either select toggles the shared pointer. A write to select 5 returns the pointer to low.
- R4: The memory address is {page, offset}. The page is written at select 2. The offset increments after each transfer and wraps from 0xFFFF to 0x0000 without changing the page.
- R5: A programmed count N produces exactly N+1 transfers.
- R6: Every transfer asserts the acknowledge strobe for one clock, together with exactly one memory strobe. Mode (select 3) bit 0 = 1 selects a memory write (peripheral to memory), and bit 0 = 0 selects a memory read. No memory strobe is raised without the acknowledge strobe.
- R7: While the request stays high and the channel is unmasked, transfers occur on consecutive clocks. When the request is low, transfers pause. When it rises again, transfers resume at the next address.
- R8: The final transfer asserts the terminal-count output in the same clock as its acknowledge strobe. After that transfer the channel is masked and the status flag is set. Later requests produce no transfer.
- R9: A read at select 6 returns {6'b0, mask, flag}. The read clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (status read clears the flag) |
| cpu_sel | input | 3 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| dreq | input | 1 | Peripheral request |
| dack | output | 1 | Transfer acknowledge strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal-count pulse on the final transfer |
| mem_addr | output | 20 | Physical address {page, offset} |

## Verification
The bench builds the block with its defaults: a 16-bit offset and a 4-bit page. With these values every case of interest is reachable in a few dozen cycles. Programming an offset of 0xFFFE brings the page-preserving wrap within three transfers. A count of zero exercises the single-transfer terminal case. A stray low byte followed by a pointer reset shows the shared byte pointer at work. Paused and resumed requests check demand-mode sequencing against a queue of expected addresses, directions and terminal flags.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    SEL_OFS    = 3'd0,
    SEL_COUNT  = 3'd1,
    SEL_PAGE   = 3'd2,
    SEL_MODE   = 3'd3,
    SEL_MASK   = 3'd4,
    SEL_CLRPTR = 3'd5,
    SEL_STATUS = 3'd6
  } reg_sel_e;

  localparam int MODE_DIR_BIT = 0;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              fire_i,
  input  logic              last_i,
  output logic              mask_o,
  output logic              dir_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [OFS_W-1:0]  count_o
);
  localparam int LO_W = OFS_W / 2;

  function automatic logic [OFS_W-1:0] ofs_step(input logic [OFS_W-1:0] a);
    return a + OFS_W'(1);
  endfunction

  function automatic logic [OFS_W-1:0] count_step(input logic [OFS_W-1:0] c);
    return c - OFS_W'(1);
  endfunction

  logic              ptr_hi_q;
  logic              mask_q, flag_q, dir_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q, count_q;

  logic wr_ofs, wr_cnt, wr_page, wr_mode, wr_mask, wr_clrptr, rd_status;
  assign wr_ofs    = wr_en && (sel == SEL_OFS);
  assign wr_cnt    = wr_en && (sel == SEL_COUNT);
  assign wr_page   = wr_en && (sel == SEL_PAGE);
  assign wr_mode   = wr_en && (sel == SEL_MODE);
  assign wr_mask   = wr_en && (sel == SEL_MASK);
  assign wr_clrptr = wr_en && (sel == SEL_CLRPTR);
  assign rd_status = rd_en && (sel == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_hi_q <= 1'b0;
      mask_q   <= 1'b1;
      flag_q   <= 1'b0;
      dir_q    <= 1'b0;
      page_q   <= '0;
      ofs_q    <= '0;
      count_q  <= '0;
    end else begin
      if (fire_i) begin
        ofs_q   <= ofs_step(ofs_q);
        count_q <= count_step(count_q);
      end
      if (wr_ofs) begin
        if (ptr_hi_q) ofs_q[OFS_W-1:LO_W] <= wdata[OFS_W-LO_W-1:0];
        else          ofs_q[LO_W-1:0]     <= wdata[LO_W-1:0];
      end
      if (wr_cnt) begin
        if (ptr_hi_q) count_q[OFS_W-1:LO_W] <= wdata[OFS_W-LO_W-1:0];
        else          count_q[LO_W-1:0]     <= wdata[LO_W-1:0];
      end
      if (wr_ofs || wr_cnt) ptr_hi_q <= ~ptr_hi_q;
      if (wr_clrptr)        ptr_hi_q <= 1'b0;
      if (wr_page) page_q <= wdata[PAGE_W-1:0];
      if (wr_mode) dir_q  <= wdata[MODE_DIR_BIT];
      if (wr_mask) mask_q <= wdata[0];
      if (last_i)  mask_q <= 1'b1;
      if (rd_status) flag_q <= 1'b0;
      if (last_i)    flag_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_status) rdata = {{(BYTE_W-2){1'b0}}, mask_q, flag_q};
  end

  assign mask_o  = mask_q;
  assign dir_o   = dir_q;
  assign page_o  = page_q;
  assign ofs_o   = ofs_q;
  assign count_o = count_q;

  // R8: the last transfer leaves the channel masked with the flag set
  assert_last_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |=> (mask_q && flag_q));

  // R3: the pointer reset command returns the pointer to the low byte
  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clrptr |=> !ptr_hi_q);

  // R4: a transfer never changes the page
  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !wr_page) |=> $stable(page_q));
endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer #(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dreq,
  input  logic                    mask_i,
  input  logic                    dir_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [OFS_W-1:0]        ofs_i,
  input  logic [OFS_W-1:0]        count_i,
  output logic                    fire_o,
  output logic                    last_o,
  output logic                    dack_o,
  output logic                    mem_rd_o,
  output logic                    mem_wr_o,
  output logic                    tc_o,
  output logic [PAGE_W+OFS_W-1:0] mem_addr_o
);
  localparam int PHYS_W = PAGE_W + OFS_W;

  function automatic logic [PHYS_W-1:0] phys(input logic [PAGE_W-1:0] p,
                                             input logic [OFS_W-1:0] o);
    return {p, o};
  endfunction

  assign fire_o = dreq && !mask_i;
  assign last_o = fire_o && (count_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dack_o     <= 1'b0;
      mem_rd_o   <= 1'b0;
      mem_wr_o   <= 1'b0;
      tc_o       <= 1'b0;
      mem_addr_o <= '0;
    end else begin
      dack_o   <= fire_o;
      mem_wr_o <= fire_o && dir_i;
      mem_rd_o <= fire_o && !dir_i;
      tc_o     <= last_o;
      if (fire_o) mem_addr_o <= phys(page_i, ofs_i);
    end
  end

  // R6: exactly one memory strobe with each acknowledge, and none without it
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dack_o |-> ($countones({mem_rd_o, mem_wr_o}) == 1));
  assert_strobe_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> dack_o);

  // R8: the terminal-count pulse only rides on a transfer
  assert_tc_on_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> dack_o);
endmodule

// File: rtl/dma_demand_chan.sv
module dma_demand_chan #(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_wr,
  input  logic                    cpu_rd,
  input  logic [2:0]              cpu_sel,
  input  logic [BYTE_W-1:0]       cpu_wdata,
  output logic [BYTE_W-1:0]       cpu_rdata,
  input  logic                    dreq,
  output logic                    dack,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic                    tc,
  output logic [PAGE_W+OFS_W-1:0] mem_addr
);
  logic              xfer_fire, xfer_last;
  logic              chan_mask, chan_dir;
  logic [PAGE_W-1:0] chan_page;
  logic [OFS_W-1:0]  chan_ofs, chan_count;

  dma_chan_regs #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr),
    .rd_en   (cpu_rd),
    .sel     (cpu_sel),
    .wdata   (cpu_wdata),
    .rdata   (cpu_rdata),
    .fire_i  (xfer_fire),
    .last_i  (xfer_last),
    .mask_o  (chan_mask),
    .dir_o   (chan_dir),
    .page_o  (chan_page),
    .ofs_o   (chan_ofs),
    .count_o (chan_count)
  );

  dma_chan_xfer #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) xfer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .mask_i     (chan_mask),
    .dir_i      (chan_dir),
    .page_i     (chan_page),
    .ofs_i      (chan_ofs),
    .count_i    (chan_count),
    .fire_o     (xfer_fire),
    .last_o     (xfer_last),
    .dack_o     (dack),
    .mem_rd_o   (mem_rd),
    .mem_wr_o   (mem_wr),
    .tc_o       (tc),
    .mem_addr_o (mem_addr)
  );

  // R2: a channel masked at an edge makes no transfer at that edge
  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_mask |=> !dack);

  // R4/R7: back-to-back transfers step the offset by one inside the same page
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && $past(dack) && $stable(chan_page)) |->
      (mem_addr[OFS_W-1:0] == OFS_W'($past(mem_addr[OFS_W-1:0]) + 1)) &&
      (mem_addr[PAGE_W+OFS_W-1:OFS_W] == $past(mem_addr[PAGE_W+OFS_W-1:OFS_W])));
endmodule

// File: tb/dma_demand_chan_tb_top.sv
module dma_demand_chan_tb_top;
  typedef struct packed {
    logic [19:0] addr;
    logic        dir;
    logic        tc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [2:0]  cpu_sel = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        dreq = 1'b0;
  logic        dack, mem_rd, mem_wr, tc;
  logic [19:0] mem_addr;

  int   checks = 0, errors = 0, dack_total = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  dma_demand_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dreq(dreq), .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .tc(tc), .mem_addr(mem_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected transfer per acknowledge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dack) begin
        dack_total++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected transfer", {12'h0, mem_addr}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.addr, "R4", "address", {12'h0, mem_addr}, {12'h0, e.addr});
          check(mem_wr == e.dir && mem_rd == !e.dir, "R6", "strobe",
                {30'h0, mem_wr, mem_rd}, {30'h0, e.dir, !e.dir});
          check(tc == e.tc, "R8", "tc pulse", {31'h0, tc}, {31'h0, e.tc});
        end
      end else if (mem_rd || mem_wr || tc) begin
        check(1'b0, "R6", "strobe without acknowledge", {29'h0, tc, mem_wr, mem_rd}, 32'h0);
      end
    end
  end

  task automatic cpu_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_sel = s;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  // driver: programs the channel and queues the transfers it expects
  task automatic setup(input logic [3:0] page, input logic [15:0] ofs,
                       input logic [15:0] cnt, input logic dir);
    cpu_write(3'd4, 8'h01);
    cpu_write(3'd3, {7'h0, dir});
    cpu_write(3'd2, {4'h0, page});
    cpu_write(3'd5, 8'h00);
    cpu_write(3'd0, ofs[7:0]);
    cpu_write(3'd0, ofs[15:8]);
    cpu_write(3'd1, cnt[7:0]);
    cpu_write(3'd1, cnt[15:8]);
    for (int i = 0; i <= int'(cnt); i++) begin
      exp_t e;
      e.addr = {page, 16'(ofs + 16'(i))};
      e.dir  = dir;
      e.tc   = (i == int'(cnt));
      exp_q.push_back(e);
    end
  endtask

  task automatic run_req(input int cycles);
    @(negedge clk);
    dreq = 1'b1;
    repeat (cycles) @(negedge clk);
    dreq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dack && !mem_rd && !mem_wr && !tc, "R1", "idle strobes after reset",
          {28'h0, dack, mem_rd, mem_wr, tc}, 32'h0);
    cpu_read(3'd6, st);
    check(st == 8'h02, "R1", "status after reset", {24'h0, st}, 32'h02);

    // R2: requests ignored while masked from reset
    snap = dack_total;
    run_req(5);
    check(dack_total == snap, "R2", "transfers while masked", snap, dack_total);

    // R7 + R5 + R9: write-to-memory, 4 bytes, with a pause
    setup(4'h3, 16'h1234, 16'd3, 1'b1);
    cpu_write(3'd4, 8'h00);
    dreq = 1'b1;
    repeat (2) @(negedge clk);
    dreq = 1'b0;
    #2 snap = dack_total;
    check(snap == 4 - exp_q.size() && snap == 2, "R7", "back-to-back count", snap, 2);
    repeat (4) @(negedge clk);
    #2 check(dack_total == snap, "R7", "pause while request low", dack_total, snap);
    run_req(6);
    check(exp_q.size() == 0, "R5", "remaining transfers", exp_q.size(), 0);
    check(dack_total == 4, "R8", "no transfer after terminal", dack_total, 4);
    cpu_read(3'd6, st);
    check(st == 8'h03, "R9", "status after terminal", {24'h0, st}, 32'h03);
    cpu_read(3'd6, st);
    check(st == 8'h02, "R9", "flag cleared by read", {24'h0, st}, 32'h02);

    // R4 wrap + R2 set-mask command: read-from-memory, 3 bytes
    setup(4'hA, 16'hFFFE, 16'd2, 1'b0);
    cpu_write(3'd4, 8'h00);
    cpu_write(3'd4, 8'h01);
    snap = dack_total;
    run_req(4);
    check(dack_total == snap, "R2", "re-masked channel idle", dack_total, snap);
    cpu_write(3'd4, 8'h00);
    run_req(8);
    check(exp_q.size() == 0 && dack_total == snap + 3, "R4", "wrap transfer count",
          dack_total, snap + 3);

    // R3: stray low byte then pointer reset; count 0 gives one transfer
    cpu_write(3'd4, 8'h01);
    cpu_write(3'd0, 8'h77);
    setup(4'h5, 16'h2010, 16'd0, 1'b1);
    cpu_write(3'd4, 8'h00);
    snap = dack_total;
    run_req(4);
    check(exp_q.size() == 0 && dack_total == snap + 1, "R3", "pointer reset / single byte",
          dack_total, snap + 1);
    cpu_read(3'd6, st);
    check(st == 8'h03, "R8", "mask and flag after single", {24'h0, st}, 32'h03);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule